// File: doc/BRIEF.md
# Float-to-integer converter with per-operation rounding

This unit turns one IEEE-754 binary floating-point operand into a 32-bit integer. A per-operation flag picks the operand width: single precision in the low half of the operand bus, or double precision across all 64 bits. A second flag picks a signed or an unsigned result. A 2-bit field chosen with each operation sets the rounding mode, so neighbouring operations may round in different ways.

The data path is a one-way stream. An operation is offered with `in_valid` and is always taken. Its result appears with `out_valid` exactly one clock later. There is no `ready` in either direction and no back-pressure, so the consumer must accept one result per cycle. Rounding works on the significand aligned to the integer point, using a guard bit and a sticky bit. A 33-bit rounded magnitude and an out-of-range flag then feed a saturation stage. NaN gives zero. Infinities and oversized values clamp to the limit of the output type.

Top module: `fp2int_conv`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. `out_result` changes only in a cycle that follows an accepted operation, and otherwise holds its value.
- R2: While `rst_n` is low, `out_valid` is 0 and `out_result` is 0.
- R3: When `in_is_double` is 0, the operand is the single-precision value in `in_operand[31:0]` and bits 63:32 are ignored. When `in_is_double` is 1, all 64 bits form a double-precision value.
- R4: With `in_rmode` = 2'b00 the result is rounded to nearest, and an exact half goes away from zero (2.5 gives 3, -2.5 gives -3, -0.5 gives -1).
- R5: With `in_rmode` = 2'b01 the result is rounded to nearest. An exact half rounds up in magnitude only when the integer part below it is odd, and a fraction above one half always rounds up in magnitude (2.5 gives 2, 3.5 gives 4, -0.5 gives 0).
- R6: With `in_rmode` = 2'b10 the result is rounded toward plus infinity (1.25 gives 2, -1.25 gives -1).
- R7: With `in_rmode` = 2'b11 the result is rounded toward minus infinity (1.25 gives 1, -1.25 gives -2).
- R8: With `in_signed` = 1, a rounded value of 2^31-1 or more gives 0x7FFFFFFF, and a rounded value below -2^31 gives 0x80000000. Values in range come out in two's complement.
- R9: With `in_signed` = 0, any rounded value that is negative or negative zero gives 0. A rounded value of 2^32-1 or more gives 0xFFFFFFFF.
- R10: A NaN operand of either width and either sign gives 0 for signed and for unsigned results.
- R11: Plus and minus infinity saturate like out-of-range finite values of the same sign. Plus and minus zero give 0.
- R12: Denormal operands are not flushed. They round to 0 in both nearest modes, to +1 toward plus infinity when positive, and to -1 toward minus infinity when negative. The unsigned clamp of R9 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered this cycle; always accepted |
| in_operand | input | 64 | Floating-point operand bits |
| in_is_double | input | 1 | 0: single precision in bits 31:0; 1: double precision |
| in_signed | input | 1 | 0: unsigned result; 1: signed result |
| in_rmode | input | 2 | 00 ties-away, 01 ties-even, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 32 | Converted integer |

## Verification
The bench goes after exact halves in both nearest modes. A design that confuses ties-away with ties-even returns 3 instead of 2 for 2.5, and one that rounds negative halves toward plus infinity returns -2 instead of -3 for -2.5. It also probes the edges of the saturation region: 2147483647.5, -2147483648.5, 4294967294.5 and 4294967295.4. An off-by-one limit or a lost rounding carry there wraps the result instead of clamping it. Other targets are negative fractions under unsigned conversion, NaN, infinities, signed zeros and single and double denormals. A flushing design gets the directed-mode results wrong for denormals, and a sign-handling slip leaks a nonzero value into an unsigned result. Single-precision operands are sent with garbage in the upper word, which exposes a mux that reads the wrong half of the bus.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int D_EXP_W = 11;
  localparam int D_MAN_W = 52;
  localparam int S_EXP_W = 8;
  localparam int S_MAN_W = 23;
  localparam int D_BIAS  = (1 << (D_EXP_W - 1)) - 1;
  localparam int S_BIAS  = (1 << (S_EXP_W - 1)) - 1;
  localparam int OPND_W  = 1 + D_EXP_W + D_MAN_W;
  localparam int SIG_W   = D_MAN_W + 1;
  localparam int EXP_W   = D_EXP_W + 2;

  typedef enum logic [1:0] {
    RM_NEAR_AWAY = 2'b00,
    RM_NEAR_EVEN = 2'b01,
    RM_TO_PINF   = 2'b10,
    RM_TO_NINF   = 2'b11
  } rmode_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic                    is_zero;
    logic [EXP_W-1:0]        exp_unb;
    logic [SIG_W-1:0]        sig;
  } fields_t;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
(
  input  logic [OPND_W-1:0] operand,
  input  logic              is_double,
  output fields_t           fields
);
  logic [D_EXP_W-1:0] d_exp;
  logic [D_MAN_W-1:0] d_man;
  logic [S_EXP_W-1:0] s_exp;
  logic [S_MAN_W-1:0] s_man;

  assign d_exp = operand[OPND_W-2 -: D_EXP_W];
  assign d_man = operand[D_MAN_W-1:0];
  assign s_exp = operand[S_EXP_W+S_MAN_W-1 -: S_EXP_W];
  assign s_man = operand[S_MAN_W-1:0];

  always_comb begin
    fields = '0;
    if (is_double) begin
      fields.sign    = operand[OPND_W-1];
      fields.is_nan  = (&d_exp) && (|d_man);
      fields.is_inf  = (&d_exp) && !(|d_man);
      fields.is_zero = !(|d_exp) && !(|d_man);
      fields.sig     = {(|d_exp), d_man};
      fields.exp_unb = (|d_exp) ? EXP_W'(d_exp) - EXP_W'(D_BIAS)
                                : EXP_W'(1) - EXP_W'(D_BIAS);
    end else begin
      fields.sign    = operand[S_EXP_W+S_MAN_W];
      fields.is_nan  = (&s_exp) && (|s_man);
      fields.is_inf  = (&s_exp) && !(|s_man);
      fields.is_zero = !(|s_exp) && !(|s_man);
      fields.sig     = {(|s_exp), s_man, {(D_MAN_W-S_MAN_W){1'b0}}};
      fields.exp_unb = (|s_exp) ? EXP_W'(s_exp) - EXP_W'(S_BIAS)
                                : EXP_W'(1) - EXP_W'(S_BIAS);
    end
  end
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  fields_t          fields,
  input  logic [1:0]       rmode,
  output logic [OUT_W:0]   mag,
  output logic             big
);
  localparam int SH_W = $clog2(SIG_W + 1);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(OUT_W);

  logic signed [EXP_W-1:0] e;
  logic [SH_W-1:0]         sh;
  logic [SIG_W-1:0]        below_mask;
  logic [OUT_W-1:0]        int_part;
  logic                    guard;
  logic                    sticky;
  logic                    inc;

  assign e = $signed(fields.exp_unb);

  // Align the significand to the integer point and split off guard/sticky.
  always_comb begin
    int_part   = '0;
    guard      = 1'b0;
    sticky     = 1'b0;
    big        = 1'b0;
    sh         = '0;
    below_mask = '0;
    if (fields.is_inf) begin
      big = 1'b1;
    end else if (!fields.is_zero && !fields.is_nan) begin
      if (e >= EXP_LIM) begin
        big = 1'b1;
      end else if (!e[EXP_W-1]) begin
        sh         = SH_W'(SIG_W - 1) - SH_W'(e[SH_W-1:0]);
        int_part   = OUT_W'(fields.sig >> sh);
        guard      = fields.sig[sh - SH_W'(1)];
        below_mask = (SIG_W'(1) << (sh - SH_W'(1))) - SIG_W'(1);
        sticky     = |(fields.sig & below_mask);
      end else if (&e) begin
        guard  = fields.sig[SIG_W-1];
        sticky = |fields.sig[SIG_W-2:0];
      end else begin
        sticky = 1'b1;
      end
    end
  end

  // Increment decision, taken in the magnitude domain.
  always_comb begin
    unique case (rmode_e'(rmode))
      RM_NEAR_AWAY: inc = guard;
      RM_NEAR_EVEN: inc = guard && (sticky || int_part[0]);
      RM_TO_PINF:   inc = !fields.sign && (guard || sticky);
      RM_TO_NINF:   inc = fields.sign && (guard || sticky);
      default:      inc = 1'b0;
    endcase
  end

  assign mag = {1'b0, int_part} + (OUT_W+1)'(inc);
endmodule

// File: rtl/fp2int_sat.sv
module fp2int_sat #(
  parameter int OUT_W = 32
) (
  input  logic             sign,
  input  logic             is_nan,
  input  logic             is_signed,
  input  logic             big,
  input  logic [OUT_W:0]   mag,
  output logic [OUT_W-1:0] result
);
  localparam logic [OUT_W-1:0] S_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_MIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] U_MAX = '1;

  always_comb begin
    if (is_nan) begin
      result = '0;
    end else if (is_signed) begin
      if (!sign)
        result = (big || mag > {1'b0, S_MAX}) ? S_MAX : mag[OUT_W-1:0];
      else
        result = (big || mag > {1'b0, S_MIN}) ? S_MIN
                                              : OUT_W'(0) - mag[OUT_W-1:0];
    end else begin
      if (sign)
        result = '0;
      else
        result = (big || mag[OUT_W]) ? U_MAX : mag[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fp2int_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       in_operand,
  input  logic              in_is_double,
  input  logic              in_signed,
  input  logic [1:0]        in_rmode,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_result
);
  fields_t          fields;
  logic [OUT_W:0]   mag;
  logic             big;
  logic [OUT_W-1:0] sat_result;

  fp2int_unpack unpack_i (
    .operand   (in_operand),
    .is_double (in_is_double),
    .fields    (fields)
  );

  fp2int_round #(.OUT_W(OUT_W)) round_i (
    .fields (fields),
    .rmode  (in_rmode),
    .mag    (mag),
    .big    (big)
  );

  fp2int_sat #(.OUT_W(OUT_W)) sat_i (
    .sign      (fields.sign),
    .is_nan    (fields.is_nan),
    .is_signed (in_signed),
    .big       (big),
    .mag       (mag),
    .result    (sat_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= sat_result;
    end
  end
endmodule

// File: rtl/fp2int_conv_chk.sv
module fp2int_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_operand,
  input logic        in_is_double,
  input logic        in_signed,
  input logic        out_valid,
  input logic [31:0] out_result
);
  logic op_nan, op_neg, op_pinf;

  always_comb begin
    if (in_is_double) begin
      op_neg  = in_operand[63];
      op_nan  = (&in_operand[62:52]) && (|in_operand[51:0]);
      op_pinf = (in_operand == 64'h7FF0_0000_0000_0000);
    end else begin
      op_neg  = in_operand[31];
      op_nan  = (&in_operand[30:23]) && (|in_operand[22:0]);
      op_pinf = (in_operand[31:0] == 32'h7F80_0000);
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  // R10
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_nan) |=> (out_result == 32'h0));
  // R9
  unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_signed && op_neg) |=> (out_result == 32'h0));
  // R8
  signed_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && !op_neg && !op_nan) |=> !out_result[31]);
  // R8
  signed_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && op_neg && !op_nan) |=>
      (out_result[31] || out_result == 32'h0));
  // R11
  pinf_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_pinf && !in_signed) |=> (out_result == 32'hFFFF_FFFF));
endmodule

bind fp2int_conv fp2int_conv_chk chk_i (.*);

// File: tb/fp2int_conv_tb.sv
`timescale 1ns/100ps
module fp2int_conv_tb_top;
  localparam logic [1:0] AWAY = 2'b00, EVEN = 2'b01, UP = 2'b10, DOWN = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic        in_is_double = 1'b0;
  logic        in_signed = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic        out_valid;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  fp2int_conv dut_i (
    .clk, .rst_n, .in_valid, .in_operand, .in_is_double,
    .in_signed, .in_rmode, .out_valid, .out_result
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] op, input logic dbl, input logic sgn,
                       input logic [1:0] rm, input logic [31:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_is_double = dbl;
    in_signed = sgn; in_rmode = rm;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic sgl(input logic [31:0] bits, input logic sgn, input logic [1:0] rm,
                     input logic [31:0] exp, input string tag);
    drive({32'hDEAD_BEEF, bits}, 1'b0, sgn, rm, exp, tag);
  endtask

  task automatic dbl(input real v, input logic sgn, input logic [1:0] rm,
                     input logic [31:0] exp, input string tag);
    drive($realtobits(v), 1'b1, sgn, rm, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard whenever a result is presented.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        check(32'h1, 32'h0, "R1 unexpected out_valid");
      end else begin
        check(out_result, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL R1 watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({31'b0, out_valid}, 32'h0, "R2 out_valid in reset");
    check(out_result, 32'h0, "R2 out_result in reset");
    rst_n = 1'b1;

    // R4 ties away
    sgl(32'h4020_0000, 1, AWAY, 32'd3,        "R4 2.5");
    sgl(32'hC020_0000, 1, AWAY, 32'hFFFF_FFFD, "R4 -2.5");
    sgl(32'h3F00_0000, 1, AWAY, 32'd1,        "R4 0.5");
    sgl(32'hBF00_0000, 1, AWAY, 32'hFFFF_FFFF, "R4 -0.5");
    sgl(32'h3FA0_0000, 1, AWAY, 32'd1,        "R4 1.25");
    sgl(32'h4030_0000, 1, AWAY, 32'd3,        "R4 2.75");
    // R5 ties even
    sgl(32'h4020_0000, 1, EVEN, 32'd2,        "R5 2.5");
    sgl(32'h4060_0000, 1, EVEN, 32'd4,        "R5 3.5");
    sgl(32'hC020_0000, 1, EVEN, 32'hFFFF_FFFE, "R5 -2.5");
    sgl(32'hBF00_0000, 1, EVEN, 32'd0,        "R5 -0.5");
    sgl(32'h3FC0_0000, 1, EVEN, 32'd2,        "R5 1.5");
    sgl(32'h4030_0000, 1, EVEN, 32'd3,        "R5 2.75");
    dbl(123456788.5,   1, EVEN, 32'h075B_CD14, "R5 123456788.5");
    dbl(123456789.5,   1, EVEN, 32'h075B_CD16, "R5 123456789.5");
    idle(2);
    // R6 toward +inf
    sgl(32'h3FA0_0000, 1, UP, 32'd2,          "R6 1.25");
    sgl(32'hBFA0_0000, 1, UP, 32'hFFFF_FFFF,  "R6 -1.25");
    sgl(32'h4000_0000, 1, UP, 32'd2,          "R6 2.0");
    sgl(32'hBE80_0000, 1, UP, 32'd0,          "R6 -0.25");
    // R7 toward -inf
    sgl(32'h3FA0_0000, 1, DOWN, 32'd1,        "R7 1.25");
    sgl(32'hBFA0_0000, 1, DOWN, 32'hFFFF_FFFE, "R7 -1.25");
    sgl(32'hBE80_0000, 1, DOWN, 32'hFFFF_FFFF, "R7 -0.25");
    sgl(32'h4030_0000, 1, DOWN, 32'd2,        "R7 2.75");
    // R3 format selection
    drive($realtobits(2.5), 1'b1, 1, AWAY, 32'd3, "R3 double 2.5");
    drive($realtobits(2.5), 1'b0, 1, AWAY, 32'd0, "R3 low word only");
    drive({32'h4020_0000, 32'h4020_0000}, 1'b0, 1, EVEN, 32'd2, "R3 upper ignored");
    // R8 signed saturation
    dbl(2147483647.0,  1, EVEN, 32'h7FFF_FFFF, "R8 max exact");
    dbl(2147483647.5,  1, EVEN, 32'h7FFF_FFFF, "R8 carry past max");
    dbl(2147483646.5,  1, DOWN, 32'h7FFF_FFFE, "R8 below max");
    dbl(-2147483647.0, 1, EVEN, 32'h8000_0001, "R8 min+1");
    dbl(-2147483648.0, 1, EVEN, 32'h8000_0000, "R8 min exact");
    dbl(-2147483648.5, 1, UP,   32'h8000_0000, "R8 min half up");
    dbl(-2147483649.0, 1, DOWN, 32'h8000_0000, "R8 below min");
    dbl(1.0e20,        1, AWAY, 32'h7FFF_FFFF, "R8 huge");
    dbl(-1.0e20,       1, AWAY, 32'h8000_0000, "R8 huge neg");
    sgl(32'h4F00_0000, 1, EVEN, 32'h7FFF_FFFF, "R8 single 2^31");
    // R9 unsigned
    dbl(4294967295.0,  0, EVEN, 32'hFFFF_FFFF, "R9 max exact");
    dbl(4294967294.5,  0, EVEN, 32'hFFFF_FFFE, "R9 tie to even");
    dbl(4294967294.5,  0, AWAY, 32'hFFFF_FFFF, "R9 tie away");
    dbl(4294967295.4,  0, UP,   32'hFFFF_FFFF, "R9 carry out");
    dbl(3000000000.0,  0, DOWN, 32'hB2D0_5E00, "R9 3e9");
    sgl(32'hBFA0_0000, 0, UP,   32'd0,        "R9 -1.25");
    sgl(32'hBE80_0000, 0, UP,   32'd0,        "R9 -0.25");
    sgl(32'h4F00_0000, 0, EVEN, 32'h8000_0000, "R9 single 2^31");
    dbl(1.0e20,        0, DOWN, 32'hFFFF_FFFF, "R9 huge");
    // R10 NaN
    sgl(32'h7FC0_0000, 1, AWAY, 32'd0, "R10 single nan signed");
    sgl(32'h7FC0_0000, 0, UP,   32'd0, "R10 single nan unsigned");
    sgl(32'hFFC0_0001, 0, DOWN, 32'd0, "R10 negative nan");
    drive(64'h7FF8_0000_0000_0000, 1'b1, 1, EVEN, 32'd0, "R10 double nan");
    // R11 infinities and zeros
    sgl(32'h7F80_0000, 1, EVEN, 32'h7FFF_FFFF, "R11 +inf signed");
    sgl(32'hFF80_0000, 1, EVEN, 32'h8000_0000, "R11 -inf signed");
    sgl(32'h7F80_0000, 0, EVEN, 32'hFFFF_FFFF, "R11 +inf unsigned");
    sgl(32'hFF80_0000, 0, EVEN, 32'd0,        "R11 -inf unsigned");
    drive(64'hFFF0_0000_0000_0000, 1'b1, 1, DOWN, 32'h8000_0000, "R11 double -inf");
    sgl(32'h0000_0000, 1, UP,   32'd0, "R11 +0");
    sgl(32'h8000_0000, 1, DOWN, 32'd0, "R11 -0");
    // R12 denormals
    sgl(32'h0000_0001, 1, AWAY, 32'd0,        "R12 tiny away");
    sgl(32'h0000_0001, 1, EVEN, 32'd0,        "R12 tiny even");
    sgl(32'h0000_0001, 1, UP,   32'd1,        "R12 tiny up");
    sgl(32'h8000_0001, 1, DOWN, 32'hFFFF_FFFF, "R12 neg tiny down");
    sgl(32'h8000_0001, 1, UP,   32'd0,        "R12 neg tiny up");
    drive(64'h0000_0000_0000_0001, 1'b1, 0, UP,   32'd1, "R12 double tiny up");
    drive(64'h8000_0000_0000_0001, 1'b1, 0, DOWN, 32'd0, "R12 unsigned clamp");
    sgl(32'h4060_0000, 1, AWAY, 32'd4, "R1 last item");
    idle(2);

    // R1: result holds while idle, scoreboard drained
    held = out_result;
    idle(4);
    check(out_result, held, "R1 hold while idle");
    check(32'(q_exp.size()), 32'd0, "R1 all results delivered");
    check({31'b0, out_valid}, 32'h0, "R1 valid low when idle");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule